// File: doc/BRIEF.md
# Signed Integer to Packed BCD Converter

This block turns a two's-complement source word into packed binary-coded decimal and reports four arithmetic status flags. A negative source is converted by its magnitude, and the sign is reported separately on its own flag. The conversion is sequential. A start pulse captures the source and the destination mode. A shift-and-add-3 engine then runs one iteration per source bit. A one-cycle done pulse marks the moment the result words and the flags become valid.

The mode input selects one of two destination shapes. The narrow shape is a single word holding four BCD digits. The wide shape is a pair of words: the low word holds the four least significant digits and the high word holds the fifth digit in its lowest nibble. In both shapes the overflow flag reports a magnitude above 9999. In the narrow shape an overflowing result is truncated to its low four digits. In the wide shape the full five-digit result stays valid.

Top module: `int_bcd_conv`

## Requirements
- R1: A negative source is converted by its absolute value, and the most negative source -32768 converts to magnitude 32768. In wide mode this gives low word 16'h2768 and high word 16'h0003.
- R2: While idle, a start_i high at a rising edge captures src_i and wide_i. Sixteen rising edges later, done_o is high for exactly one cycle. The result words and flags update at that edge and hold until the next done_o.
- R3: ovf_o is set exactly when the converted magnitude exceeds 9999. This holds in both modes.
- R4: Narrow mode (wide_i=0) places BCD digit k in lo_word_o bits 4k+3:4k, for k=0..3, and drives hi_word_o to zero. On overflow, lo_word_o keeps the low four digits of the result.
- R5: Wide mode (wide_i=1) fills lo_word_o as in R4 and places the fifth digit (ten-thousands) in hi_word_o bits 3:0. Bits 15:4 of hi_word_o are always zero.
- R6: zero_o is set exactly when the destination is zero. In narrow mode the destination is lo_word_o. In wide mode it is both words together.
- R7: sign_o equals bit 15 of the captured source.
- R8: carry_o is zero after every conversion.
- R9: A start_i high while a conversion is running is ignored. The running conversion completes on its original schedule with its original result.
- R10: During and after reset, all result words and flags are zero and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a conversion when idle |
| src_i | input | 16 | Two's-complement source |
| wide_i | input | 1 | 1 = five-digit two-word destination, 0 = four-digit word |
| done_o | output | 1 | One-cycle pulse, results valid |
| lo_word_o | output | 16 | Four least significant BCD digits |
| hi_word_o | output | 16 | Fifth BCD digit in bits 3:0 (wide mode), else zero |
| carry_o | output | 1 | Carry flag, always cleared |
| ovf_o | output | 1 | Magnitude above 9999 |
| zero_o | output | 1 | Destination is zero |
| sign_o | output | 1 | Source was negative |

## Verification
The bench builds the block with its default parameters: a 16-bit source, a five-digit engine and a four-digit narrow word. With these widths the full signed range can be driven, including both extremes 32767 and -32768. The 9999/10000 overflow boundary can also be driven in both modes. Because the narrow limit sits one digit below the engine width, the case where a truncated narrow word reads zero while overflow is set (magnitude 10000) is reachable.

// File: rtl/int_bcd_pkg.sv
package int_bcd_pkg;
  typedef struct packed {
    logic carry;
    logic ovf;
    logic zero;
    logic sign;
  } bcd_flags_t;
endpackage

// File: rtl/int_bcd_abs.sv
module int_bcd_abs #(
  parameter int SRC_W = 16
) (
  input  logic [SRC_W-1:0] src_i,
  output logic [SRC_W-1:0] mag_o,
  output logic             neg_o
);
  assign neg_o = src_i[SRC_W-1];
  // unsigned view: the most negative value maps to 2**(SRC_W-1)
  assign mag_o = neg_o ? (~src_i + 1'b1) : src_i;
endmodule

// File: rtl/int_bcd_dabble.sv
module int_bcd_dabble #(
  parameter int BIN_W = 16,
  parameter int DIG_N = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BIN_W-1:0]   bin_i,
  output logic               busy_o,
  output logic               last_o,
  output logic [DIG_N*4-1:0] bcd_nxt_o
);
  localparam int BCD_W = DIG_N * 4;
  localparam int CNT_W = (BIN_W > 1) ? $clog2(BIN_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIN_W - 1);

  logic [BCD_W-1:0] bcd_q, adj;
  logic [BIN_W-1:0] bin_q, bin_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  for (genvar d = 0; d < DIG_N; d++) begin : g_dig
    logic [3:0] dig;
    assign dig = bcd_q[d*4 +: 4];
    assign adj[d*4 +: 4] = (dig >= 4'd5) ? dig + 4'd3 : dig;
  end

  assign {bcd_nxt_o, bin_nxt} = {adj, bin_q} << 1;
  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcd_q  <= '0;
      bin_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      bcd_q <= bcd_nxt_o;
      bin_q <= bin_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
    end else if (load_i) begin
      bcd_q  <= '0;
      bin_q  <= bin_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end
  end

  // a running conversion cannot be cut short by a new start
  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> busy_q);
  assert_busy_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_q);
endmodule

// File: rtl/int_bcd_flags.sv
module int_bcd_flags
  import int_bcd_pkg::*;
#(
  parameter int SRC_W   = 16,
  parameter int DIG_N   = 5,
  parameter int NAR_DIG = 4
) (
  input  logic [DIG_N*4-1:0]   bcd_i,
  input  logic [SRC_W-1:0]     mag_i,
  input  logic                 neg_i,
  input  logic                 wide_i,
  output logic [NAR_DIG*4-1:0] lo_o,
  output logic [NAR_DIG*4-1:0] hi_o,
  output bcd_flags_t           flags_o
);
  localparam int WORD_W = NAR_DIG * 4;
  localparam int HI_W   = (DIG_N - NAR_DIG) * 4;
  localparam int LIMIT  = (10 ** NAR_DIG) - 1;

  logic [HI_W-1:0] hi_dig;

  assign lo_o   = bcd_i[WORD_W-1:0];
  assign hi_dig = bcd_i[DIG_N*4-1:WORD_W];
  assign hi_o   = wide_i ? WORD_W'(hi_dig) : '0;

  always_comb begin
    flags_o.carry = 1'b0;
    flags_o.ovf   = 32'(mag_i) > LIMIT;
    flags_o.zero  = wide_i ? (bcd_i == '0) : (lo_o == '0);
    flags_o.sign  = neg_i;
  end
endmodule

// File: rtl/int_bcd_conv.sv
module int_bcd_conv
  import int_bcd_pkg::*;
#(
  parameter int SRC_W   = 16,
  parameter int DIG_N   = 5,
  parameter int NAR_DIG = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [SRC_W-1:0]     src_i,
  input  logic                 wide_i,
  output logic                 done_o,
  output logic [NAR_DIG*4-1:0] lo_word_o,
  output logic [NAR_DIG*4-1:0] hi_word_o,
  output logic                 carry_o,
  output logic                 ovf_o,
  output logic                 zero_o,
  output logic                 sign_o
);
  localparam int WORD_W = NAR_DIG * 4;

  logic [SRC_W-1:0]   mag, mag_q;
  logic               neg, neg_q, wide_q;
  logic               busy, last, load;
  logic [DIG_N*4-1:0] bcd_nxt;
  logic [WORD_W-1:0]  lo_c, hi_c, lo_q, hi_q;
  bcd_flags_t         flags_c, flags_q;
  logic               done_q;

  int_bcd_abs #(.SRC_W(SRC_W)) u_abs (
    .src_i (src_i),
    .mag_o (mag),
    .neg_o (neg)
  );

  assign load = start_i && !busy;

  int_bcd_dabble #(.BIN_W(SRC_W), .DIG_N(DIG_N)) u_dabble (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .bin_i     (mag),
    .busy_o    (busy),
    .last_o    (last),
    .bcd_nxt_o (bcd_nxt)
  );

  int_bcd_flags #(.SRC_W(SRC_W), .DIG_N(DIG_N), .NAR_DIG(NAR_DIG)) u_flags (
    .bcd_i   (bcd_nxt),
    .mag_i   (mag_q),
    .neg_i   (neg_q),
    .wide_i  (wide_q),
    .lo_o    (lo_c),
    .hi_o    (hi_c),
    .flags_o (flags_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q   <= '0;
      neg_q   <= 1'b0;
      wide_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        mag_q  <= mag;
        neg_q  <= neg;
        wide_q <= wide_i;
      end
      if (last) begin
        lo_q    <= lo_c;
        hi_q    <= hi_c;
        flags_q <= flags_c;
      end
    end
  end

  assign done_o    = done_q;
  assign lo_word_o = lo_q;
  assign hi_word_o = hi_q;
  assign carry_o   = flags_q.carry;
  assign ovf_o     = flags_q.ovf;
  assign zero_o    = flags_q.zero;
  assign sign_o    = flags_q.sign;

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // overflow comes from the magnitude, the high word from the engine
  assert_wide_ovf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && wide_q) |-> (ovf_o == (hi_word_o != '0)));
  assert_narrow_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wide_q) |-> (hi_word_o == '0));
  assert_hi_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hi_word_o[WORD_W-1:4] == '0));
  assert_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && zero_o) |-> (lo_word_o == '0 && hi_word_o == '0));

  for (genvar d = 0; d < NAR_DIG; d++) begin : g_chk
    assert_digit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (lo_word_o[d*4 +: 4] <= 4'd9));
  end
endmodule

// File: tb/int_bcd_conv_test.sv
module int_bcd_conv_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [15:0] src = '0;
  logic        wide = 1'b0;
  logic        done;
  logic [15:0] lo, hi;
  logic        c, v, z, s;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  int_bcd_conv uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .src_i(src), .wide_i(wide),
    .done_o(done), .lo_word_o(lo), .hi_word_o(hi),
    .carry_o(c), .ovf_o(v), .zero_o(z), .sign_o(s)
  );

  // behavioural reference
  typedef struct {
    logic [15:0] lo, hi;
    logic c, v, z, s;
  } res_t;

  function automatic res_t model(logic [15:0] x, logic w);
    res_t r;
    int sv, m, p;
    int d[5];
    sv = $signed(x);
    m  = (sv < 0) ? -sv : sv;
    p  = 1;
    for (int k = 0; k < 5; k++) begin
      d[k] = (m / p) % 10;
      p = p * 10;
    end
    r.lo = {4'(d[3]), 4'(d[2]), 4'(d[1]), 4'(d[0])};
    r.hi = w ? 16'(d[4]) : 16'h0;
    r.c  = 1'b0;
    r.v  = m > 9999;
    r.z  = w ? (m == 0) : (r.lo == 16'h0);
    r.s  = x[15];
    return r;
  endfunction

  res_t exp_r;
  logic exp_done = 1'b0;
  bit   m_busy = 0;
  int   m_cnt = 0;
  logic [15:0] m_src = '0;
  logic m_wide = 1'b0;

  initial begin
    exp_r.lo = '0; exp_r.hi = '0;
    exp_r.c = 0; exp_r.v = 0; exp_r.z = 0; exp_r.s = 0;
  end

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_busy = 0; exp_done = 0;
    end else if (!m_busy && start) begin
      m_busy = 1; m_cnt = 0; m_src = src; m_wide = wide; exp_done = 0;
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == 16) begin
        m_busy = 0; exp_done = 1; exp_r = model(m_src, m_wide);
      end else exp_done = 0;
    end else exp_done = 0;
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  // compare on every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      chk(done == exp_done, "R2 done", done, exp_done);
      chk(lo == exp_r.lo, m_src[15] ? "R1 lo" : (m_wide ? "R5 lo" : "R4 lo"), lo, exp_r.lo);
      chk(hi == exp_r.hi, m_wide ? "R5 hi" : "R4 hi", hi, exp_r.hi);
      chk(v == exp_r.v, "R3 ovf", v, exp_r.v);
      chk(z == exp_r.z, "R6 zero", z, exp_r.z);
      chk(s == exp_r.s, "R7 sign", s, exp_r.s);
      chk(c == 1'b0, "R8 carry", c, 0);
    end
  end

  task automatic run(logic [15:0] x, logic w);
    res_t r;
    @(negedge clk); start = 1; src = x; wide = w;
    @(negedge clk); start = 0;
    repeat (16) @(negedge clk);
    r = model(x, w);
    chk(done == 1'b1, "R2 done at 16", done, 1);
    chk(lo == r.lo && hi == r.hi, "R4 R5 words", {hi, lo}, {r.hi, r.lo});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({done, lo, hi, c, v, z, s} == '0, "R10 reset", {lo, hi}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk({done, lo, hi, c, v, z, s} == '0, "R10 after reset", {lo, hi}, 0);

    run(16'd0, 0);
    run(16'd0, 1);
    run(16'd9999, 0);
    run(16'd10000, 0);      // truncated word is zero, overflow set
    chk(z && v && lo == 16'h0, "R6 zero with ovf", {z, v}, 3);
    run(16'd10000, 1);
    run(16'd32767, 1);
    chk(lo == 16'h2767 && hi == 16'h3 && v, "R5 max", {hi, lo}, 32'h0003_2767);
    run(16'h8000, 1);
    chk(lo == 16'h2768 && hi == 16'h3 && s && v, "R1 most negative", {hi, lo}, 32'h0003_2768);
    run(16'h8000, 0);
    chk(lo == 16'h2768 && hi == 16'h0, "R4 truncate", {hi, lo}, 32'h2768);
    run(-16'sd1, 0);
    chk(lo == 16'h0001 && s, "R1 minus one", lo, 1);
    run(-16'sd12345, 1);
    run(16'd1234, 0);
    run(16'd5, 1);
    for (int i = 0; i < 12; i++) run(16'(i * 2731 + 7), 1'(i & 1));

    // R9: start during conversion ignored
    @(negedge clk); start = 1; src = 16'd4321; wide = 0;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    start = 1; src = 16'd777; wide = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk(done && lo == 16'h4321 && hi == 16'h0, "R9 ignored start", lo, 16'h4321);

    // back-to-back start right after done
    run(-16'sd9999, 1);
    run(16'd10001, 1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule